// File: doc/BRIEF.md
# Triggered Noise and Triangle Waveform Adder

This block sits in front of one converter channel's output register. It adds a waveform to a 12-bit base sample. The waveform is either pseudo-random noise or a triangle, and the 12-bit result is what the converter receives. The generator advances only on accepted trigger pulses. Between triggers the output holds its value. When triggering is off, the base value passes straight through.

One 4-bit amplitude code does two jobs. In noise mode it selects how many low bits of the shift register reach the adder. In triangle mode it sets the peak of the up/down count. The mode and amplitude settings can be written only while the channel is disabled. Disabling the channel also restarts both generators, so every enable period begins from the same known waveform state.

Top module: `trig_wave_adder`

## Requirements
- R1: After reset, sum_out is 0, the wave mode is off (code 00) and the amplitude code is 0.
- R2: A cycle with chan_en low makes sum_out 0 on the next edge. It also returns the shift register to its seed and the triangle to count 0, direction up.
- R3: With chan_en high and trig_en low, sum_out takes the base_in value of the previous cycle, and no waveform is added.
- R4: With chan_en and trig_en high and trig low, sum_out keeps its value and neither generator moves.
- R5: cfg_wr loads mode_in and amp_in only in a cycle where chan_en is low. A write while the channel is enabled is ignored.
- R6: Amplitude code k (0 to 11) builds a mask with bits k down to 0 set. Codes 12 to 15 act as code 11 (all 12 bits set).
- R7: Mode 01 is noise. The 12-bit shift register starts at seed 0xACE. On each accepted trigger it shifts left, and its new bit 0 is the XOR of bits 11, 5, 3 and 0. The new state ANDed with the mask is added to base_in.
- R8: Mode 10 or 11 is triangle. On each accepted trigger the count first rises by one until it equals the mask, then falls by one until it reaches 0, and then repeats. The count after the step is added to base_in.
- R9: The addition saturates: any sum above 0xFFF gives 0xFFF.
- R10: Mode 00 adds nothing. An accepted trigger then loads base_in unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; when low, locks nothing and clears the generators |
| trig_en | input | 1 | Trigger mode enable; when low, the base value is passed through |
| trig | input | 1 | Trigger pulse, accepted when chan_en and trig_en are high |
| cfg_wr | input | 1 | Write strobe for the mode and amplitude settings |
| mode_in | input | 2 | Wave mode: 00 off, 01 noise, 10/11 triangle |
| amp_in | input | 4 | Amplitude / mask code |
| base_in | input | 12 | Base sample to which the waveform is added |
| sum_out | output | 12 | Saturated sum sent to the output register |

## Verification
The bench builds the block with its default 12-bit width, 4-bit code and seed 0xACE. At this width a single directed run of more than 8,190 triggers is short enough to walk a code-11 triangle all the way to 0xFFF and back down. Base values near full scale make saturation happen on most triggers. The random episodes vary mode, amplitude, trigger density and trigger enable, and they try writing the settings while the channel is enabled.

// File: rtl/trig_wave_pkg.sv
package trig_wave_pkg;
    typedef enum logic [1:0] {
        WAVE_OFF   = 2'b00,
        WAVE_NOISE = 2'b01,
        WAVE_TRI   = 2'b10,
        WAVE_TRI_B = 2'b11
    } wave_mode_e;
endpackage

// File: rtl/trig_wave_cfg.sv
module trig_wave_cfg #(
    parameter int AMP_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      chan_en,
    input  logic                      cfg_wr,
    input  logic [1:0]                mode_in,
    input  logic [AMP_W-1:0]          amp_in,
    output trig_wave_pkg::wave_mode_e mode_q,
    output logic [AMP_W-1:0]          amp_q
);
    import trig_wave_pkg::*;

    typedef struct packed {
        wave_mode_e       mode;
        logic [AMP_W-1:0] amp;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // settings are locked while the channel runs
        if (cfg_wr && !chan_en) begin
            st_d.mode = wave_mode_e'(mode_in);
            st_d.amp  = amp_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: WAVE_OFF, amp: '0};
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign amp_q  = st_q.amp;
endmodule

// File: rtl/trig_wave_lfsr.sv
module trig_wave_lfsr #(
    parameter int          W    = 12,
    parameter logic [W-1:0] SEED = 12'hACE,
    parameter logic [W-1:0] TAPS = 12'h829
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] state_q,
    output logic [W-1:0] state_d
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;
    logic  fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.sr & TAPS);
        if (clr)       st_d.sr = SEED;
        else if (step) st_d.sr = {st_q.sr[W-2:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: SEED};
        else        st_q <= st_d;
    end

    assign state_q = st_q.sr;
    assign state_d = st_d.sr;
endmodule

// File: rtl/trig_wave_tri.sv
module trig_wave_tri #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] peak,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } tri_t;

    tri_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (step) begin
            if (!st_q.down) begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.down = (st_d.cnt == peak);
            end else begin
                st_d.cnt  = st_q.cnt - 1'b1;
                st_d.down = (st_d.cnt != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, down: 1'b0};
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
    assign cnt_d = st_d.cnt;
endmodule

// File: rtl/trig_wave_adder.sv
module trig_wave_adder #(
    parameter int                 DATA_W = 12,
    parameter int                 AMP_W  = 4,
    parameter logic [DATA_W-1:0]  SEED   = 12'hACE,
    parameter logic [DATA_W-1:0]  TAPS   = 12'h829
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              trig_en,
    input  logic              trig,
    input  logic              cfg_wr,
    input  logic [1:0]        mode_in,
    input  logic [AMP_W-1:0]  amp_in,
    input  logic [DATA_W-1:0] base_in,
    output logic [DATA_W-1:0] sum_out
);
    import trig_wave_pkg::*;

    localparam int TOP_CODE = DATA_W - 1;

    wave_mode_e        mode_q;
    logic [AMP_W-1:0]  amp_q;
    logic [DATA_W-1:0] wave_mask;
    logic [DATA_W-1:0] lfsr_q, lfsr_d;
    logic [DATA_W-1:0] tri_q, tri_d;
    logic [DATA_W-1:0] wave_val;
    logic [DATA_W:0]   raw_sum;
    logic [DATA_W-1:0] sat_sum;
    logic              accept, gen_clr;

    typedef struct packed {
        logic [DATA_W-1:0] out;
    } out_t;

    out_t st_d, st_q;

    trig_wave_cfg #(.AMP_W(AMP_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_wr(cfg_wr),
        .mode_in(mode_in), .amp_in(amp_in), .mode_q(mode_q), .amp_q(amp_q)
    );

    // mask: code k sets bits k..0, codes past the width saturate
    always_comb begin
        if (int'(amp_q) >= TOP_CODE) wave_mask = '1;
        else                         wave_mask = {DATA_W{1'b1}} >> (TOP_CODE - int'(amp_q));
    end

    assign accept  = chan_en && trig_en && trig;
    assign gen_clr = !chan_en;

    trig_wave_lfsr #(.W(DATA_W), .SEED(SEED), .TAPS(TAPS)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .clr(gen_clr),
        .step(accept && (mode_q == WAVE_NOISE)),
        .state_q(lfsr_q), .state_d(lfsr_d)
    );

    trig_wave_tri #(.W(DATA_W)) i_tri (
        .clk(clk), .rst_n(rst_n), .clr(gen_clr),
        .step(accept && mode_q[1]), .peak(wave_mask),
        .cnt_q(tri_q), .cnt_d(tri_d)
    );

    always_comb begin
        unique case (mode_q)
            WAVE_NOISE:          wave_val = lfsr_d & wave_mask;
            WAVE_TRI, WAVE_TRI_B: wave_val = tri_d;
            default:             wave_val = '0;
        endcase
        raw_sum = {1'b0, base_in} + {1'b0, wave_val};
        sat_sum = raw_sum[DATA_W] ? {DATA_W{1'b1}} : raw_sum[DATA_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (!chan_en)      st_d.out = '0;
        else if (!trig_en) st_d.out = base_in;
        else if (trig)     st_d.out = sat_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{out: '0};
        else        st_q <= st_d;
    end

    assign sum_out = st_q.out;
endmodule

// File: rtl/trig_wave_adder_chk.sv
module trig_wave_adder_chk #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_en,
    input logic              trig_en,
    input logic              trig,
    input logic [DATA_W-1:0] base_in,
    input logic [DATA_W-1:0] sum_out,
    input logic [1:0]        mode_q,
    input logic [AMP_W-1:0]  amp_q,
    input logic [DATA_W-1:0] tri_q,
    input logic [DATA_W-1:0] wave_mask,
    input logic [DATA_W-1:0] lfsr_q
);
    // R2
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> sum_out == '0);
    // R3
    bypass_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && !trig_en |=> sum_out == $past(base_in));
    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && trig_en && !trig |=> $stable(sum_out));
    // R5
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(mode_q) && $stable(amp_q));
    // R8
    tri_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tri_q <= wave_mask);
    // R7
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    // R9
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && trig_en && trig |=> sum_out >= $past(base_in));
endmodule

bind trig_wave_adder trig_wave_adder_chk #(.DATA_W(DATA_W), .AMP_W(AMP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en), .trig(trig),
    .base_in(base_in), .sum_out(sum_out), .mode_q(mode_q), .amp_q(amp_q),
    .tri_q(tri_q), .wave_mask(wave_mask), .lfsr_q(lfsr_q)
);

// File: tb/test_trig_wave_adder.sv
module test_trig_wave_adder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0, trig_en = 1'b0, trig = 1'b0, cfg_wr = 1'b0;
    logic [1:0]  mode_in = '0;
    logic [3:0]  amp_in = '0;
    logic [11:0] base_in = '0;
    logic [11:0] sum_out;

    int n_run = 0, n_fail = 0;
    bit timed_out = 1'b0;

    // bench model state
    logic [1:0]  m_mode = 2'b00;
    logic [3:0]  m_amp  = 4'd0;
    logic [11:0] m_lfsr = 12'hACE;
    logic [11:0] m_tri  = '0;
    bit          m_down = 1'b0;
    logic [11:0] m_out  = '0;

    trig_wave_adder i_trig_wave_adder (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_en(trig_en), .trig(trig),
        .cfg_wr(cfg_wr), .mode_in(mode_in), .amp_in(amp_in), .base_in(base_in),
        .sum_out(sum_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] mask_of(input logic [3:0] code);
        int k = (code > 4'd11) ? 11 : int'(code);
        return 12'((1 << (k + 1)) - 1);
    endfunction

    function automatic logic [11:0] lfsr_next(input logic [11:0] s);
        return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

    function automatic logic [11:0] sat_add(input logic [11:0] a, input logic [11:0] b);
        int s = int'(a) + int'(b);
        return (s > 4095) ? 12'hFFF : 12'(s);
    endfunction

    task automatic check(input string tag, input logic [11:0] exp);
        n_run++;
        if (sum_out !== exp) begin
            n_fail++;
            $display("FAIL %s: sum_out=%h expected=%h", tag, sum_out, exp);
        end
    endtask

    // model one edge using current inputs, then compare after the edge
    task automatic cycle(input string tag);
        logic [11:0] w = '0;
        if (cfg_wr && !chan_en) begin m_mode = mode_in; m_amp = amp_in; end
        if (!chan_en) begin
            m_lfsr = 12'hACE; m_tri = '0; m_down = 1'b0; m_out = '0;
        end else if (!trig_en) begin
            m_out = base_in;
        end else if (trig) begin
            if (m_mode == 2'b01) begin
                m_lfsr = lfsr_next(m_lfsr);
                w = m_lfsr & mask_of(m_amp);
            end else if (m_mode[1]) begin
                if (!m_down) begin
                    m_tri++; m_down = (m_tri == mask_of(m_amp));
                end else begin
                    m_tri--; m_down = (m_tri != 0);
                end
                w = m_tri;
            end
            m_out = sat_add(base_in, w);
        end
        @(posedge clk);
        #1;
        check(tag, m_out);
    endtask

    function automatic string tag_now();
        if (!chan_en)  return "R2";
        if (!trig_en)  return "R3";
        if (!trig)     return "R4";
        if (m_mode == 2'b01) return "R7";
        if (m_mode[1]) return "R8";
        return "R10";
    endfunction

    task automatic configure(input logic [1:0] md, input logic [3:0] am);
        chan_en = 0; cfg_wr = 1; mode_in = md; amp_in = am; trig = 0;
        cycle("R5");
        cfg_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        timed_out = 1'b1;
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", 12'h000);
        rst_n = 1'b1;

        // R1: defaults are mode off, code 0 -> triggers add nothing
        chan_en = 1; trig_en = 1; base_in = 12'h123; trig = 1;
        cycle("R1");
        check("R10", 12'h123);

        // R8/R6: code 0 triangle toggles 0,1
        configure(2'b10, 4'd0);
        chan_en = 1; trig_en = 1; base_in = 12'h100;
        for (int i = 0; i < 6; i++) begin trig = 1; cycle("R8"); end

        // R5: write while enabled ignored; triangle continues
        cfg_wr = 1; mode_in = 2'b01; amp_in = 4'd11; trig = 1;
        cycle("R5");
        cfg_wr = 0;
        for (int i = 0; i < 4; i++) cycle("R5");

        // R6: code 15 acts as 11, full triangle to 0xFFF and back
        configure(2'b11, 4'd15);
        chan_en = 1; trig_en = 1; base_in = 12'h000; trig = 1;
        for (int i = 0; i < 8200; i++) cycle("R6");

        // R9: saturation near full scale
        configure(2'b10, 4'd7);
        chan_en = 1; base_in = 12'hFF0; trig = 1;
        for (int i = 0; i < 40; i++) cycle("R9");
        check("R9", 12'hFFF);

        // R7: noise with every mask code
        for (int c = 0; c < 16; c++) begin
            configure(2'b01, 4'(c));
            chan_en = 1; trig_en = 1; trig = 1; base_in = 12'h400;
            for (int i = 0; i < 20; i++) cycle("R7");
        end

        // random episodes
        for (int ep = 0; ep < 300; ep++) begin
            configure(2'($urandom_range(3)), 4'($urandom_range(15)));
            chan_en = 1;
            for (int i = 0; i < 80; i++) begin
                trig_en = ($urandom_range(9) != 0);
                trig    = $urandom_range(1);
                cfg_wr  = ($urandom_range(15) == 0);
                mode_in = 2'($urandom_range(3));
                amp_in  = 4'($urandom_range(15));
                base_in = (ep % 4 == 0) ? 12'($urandom_range(4095, 3800))
                                        : 12'($urandom_range(4095));
                if ($urandom_range(39) == 0) chan_en = 0;
                cycle(tag_now());
                chan_en = 1;
            end
            cfg_wr = 0;
        end

        if (!timed_out) begin
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule